// File: doc/BRIEF.md
# Fieldbus Character Receiver with Idle-Run Frame Detection

This block receives the serial stream of a token-passing, multi-master fieldbus from an RS485 transceiver. It oversamples the line sixteen times per bit and decodes 11-bit characters. Each character has a start bit, eight data bits sent least significant bit first, an even parity bit and a stop bit. Inside a telegram the characters follow one another with no idle time between them. A telegram ends, and the token may pass, once the line has stayed at '1' for eleven whole bit times. The receiver counts these idle bit times on the raw line and gives a one-cycle pulse when the run completes.

Each decoded byte goes into a show-ahead buffer together with its parity and framing flags. The first byte after a completed idle run is tagged as start of frame. A completed idle run that follows received bytes writes an end-of-frame marker entry. A host reads the buffer one entry at a time, for example through a SPI bridge. The bit period is set at run time through a divider input, so every bus rate the divider can reach is usable. A full buffer drops new entries and raises a sticky overflow flag, which the host clears with a strobe.

Top module: `fbus_rx`

## Requirements
- R1: A character is a low start bit, eight data bits least significant bit first, a parity bit and a stop bit. The decoded byte appears in bits [7:0] of its buffer entry.
- R2: A start bit is accepted only if the line is still low half a bit time after the falling edge was seen. A shorter low pulse produces no buffer entry.
- R3: Bit [8] of a byte entry is 1 when the eight data bits and the parity bit together hold an odd number of ones, and 0 otherwise.
- R4: Bit [9] of a byte entry is 1 when the stop bit is sampled low. The receiver then accepts no start bit until the line has returned high.
- R5: `sync_pulse` is high for exactly one clock when the line has been high for eleven consecutive bit times. It pulses once per unbroken high run, and any low sample restarts the count.
- R6: Bits [11:10] of an entry hold its tag: 0 for a data byte, 1 for the first byte after a `sync_pulse`, 2 for an end-of-frame marker.
- R7: A `sync_pulse` that follows at least one received byte writes a marker entry with tag 2 and all other bits zero. A `sync_pulse` with no byte since the previous one writes nothing.
- R8: Entries are read in the order they were written. `rd_data` shows the oldest entry while `rd_valid` is high, and `rd_en` removes it. `rd_en` on an empty buffer has no effect.
- R9: When the buffer holds DEPTH entries, a new entry is dropped and `overflow` is set. `overflow` stays high until `clr_ovf` is pulsed, and clears on the clock after the pulse.
- R10: One bit time lasts 16 × (`div_val` + 1) clock cycles. A change of `div_val` takes effect on the following bits.
- R11: After reset the buffer is empty and `overflow` and `sync_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Received serial line from the transceiver, idle high |
| div_val | input | DIV_W | Oversample divider; bit time is 16 × (div_val + 1) clocks |
| rd_en | input | 1 | Removes the oldest buffer entry |
| clr_ovf | input | 1 | Strobe that clears the overflow flag |
| rd_data | output | 12 | Oldest entry: tag [11:10], framing error [9], parity error [8], byte [7:0] |
| rd_valid | output | 1 | Buffer holds at least one entry |
| overflow | output | 1 | Sticky flag: an entry was dropped because the buffer was full |
| sync_pulse | output | 1 | One-cycle pulse at the end of an eleven-bit idle run |

## Verification
A decoder whose oversample phase drifts shows up at the ports within one character: the byte or its parity flag is wrong in the next entry read. A stale start-of-frame or seen-byte flag shows up at the next idle run, as a wrong tag or as an end-of-frame marker that is missing or extra. An idle counter that does not clear on a low sample shows up as a miscounted `sync_pulse` within eleven bit times. A full-buffer condition that is tracked wrongly appears as a wrong `overflow` level or a wrong number of entries when the buffer is drained.

// File: rtl/fbr_pkg.sv
package fbr_pkg;
   localparam int OVS        = 16;  // samples per bit
   localparam int BYTE_W     = 8;
   localparam int IDLE_RUN   = 11;  // bit times of '1' that close a frame
   localparam int ENTRY_W    = 12;

   typedef enum logic [1:0] {
      TAG_DATA = 2'd0,
      TAG_SOF  = 2'd1,
      TAG_EOF  = 2'd2
   } fbr_tag_e;

   typedef struct packed {
      fbr_tag_e          tag;
      logic              ferr;
      logic              perr;
      logic [BYTE_W-1:0] data;
   } fbr_entry_t;
endpackage

// File: rtl/fbr_tick.sv
module fbr_tick #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_val,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   assign tick = (cnt >= div_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else if (tick) cnt <= '0;
      else cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/fbr_char.sv
module fbr_char
   import fbr_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rx,
   output logic              vld,
   output logic [BYTE_W-1:0] data,
   output logic              perr,
   output logic              ferr
);
   localparam int PH_W = $clog2(OVS);
   localparam int BI_W = $clog2(BYTE_W);
   localparam logic [PH_W-1:0] PH_MID  = PH_W'(OVS/2 - 1);
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVS - 1);
   localparam logic [BI_W-1:0] BI_LAST = BI_W'(BYTE_W - 1);

   typedef enum logic [2:0] {
      S_HUNT, S_START, S_DATA, S_PAR, S_STOP, S_WAITHI
   } st_e;

   st_e               st;
   logic [PH_W-1:0]   ph;
   logic [BI_W-1:0]   bidx;
   logic [BYTE_W-1:0] sh;
   logic              par_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= S_HUNT;
         ph    <= '0;
         bidx  <= '0;
         sh    <= '0;
         par_s <= 1'b0;
         vld   <= 1'b0;
         data  <= '0;
         perr  <= 1'b0;
         ferr  <= 1'b0;
      end else begin
         vld <= 1'b0;
         if (tick) begin
            case (st)
               S_HUNT: begin
                  if (!rx) begin
                     st <= S_START;
                     ph <= '0;
                  end
               end
               S_START: begin
                  if (ph == PH_MID) begin
                     ph   <= '0;
                     bidx <= '0;
                     st   <= rx ? S_HUNT : S_DATA;
                  end else ph <= ph + 1'b1;
               end
               S_DATA: begin
                  if (ph == PH_LAST) begin
                     ph <= '0;
                     sh <= {rx, sh[BYTE_W-1:1]};
                     if (bidx == BI_LAST) st <= S_PAR;
                     else bidx <= bidx + 1'b1;
                  end else ph <= ph + 1'b1;
               end
               S_PAR: begin
                  if (ph == PH_LAST) begin
                     ph    <= '0;
                     par_s <= rx;
                     st    <= S_STOP;
                  end else ph <= ph + 1'b1;
               end
               S_STOP: begin
                  if (ph == PH_LAST) begin
                     ph   <= '0;
                     vld  <= 1'b1;
                     data <= sh;
                     perr <= (^sh) ^ par_s;
                     ferr <= !rx;
                     st   <= rx ? S_HUNT : S_WAITHI;
                  end else ph <= ph + 1'b1;
               end
               S_WAITHI: begin
                  if (rx) st <= S_HUNT;
               end
               default: st <= S_HUNT;
            endcase
         end
      end
   end
endmodule

// File: rtl/fbr_idle.sv
module fbr_idle
   import fbr_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic rx,
   output logic sync
);
   localparam int PH_W  = $clog2(OVS);
   localparam int RUN_W = $clog2(IDLE_RUN + 1);
   localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(OVS - 1);
   localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(IDLE_RUN);
   localparam logic [RUN_W-1:0] RUN_PRE  = RUN_W'(IDLE_RUN - 1);

   logic [PH_W-1:0]  sub;
   logic [RUN_W-1:0] bits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sub  <= '0;
         bits <= '0;
         sync <= 1'b0;
      end else begin
         sync <= 1'b0;
         if (tick) begin
            if (!rx) begin
               sub  <= '0;
               bits <= '0;
            end else if (bits != RUN_FULL) begin
               sub <= sub + 1'b1;
               if (sub == PH_LAST) begin
                  bits <= bits + 1'b1;
                  if (bits == RUN_PRE) sync <= 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/fbr_fifo.sv
module fbr_fifo #(
   parameter int DEPTH = 256,
   parameter int W     = 12,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         rd_en,
   output logic [W-1:0] rd_data,
   output logic         rd_valid,
   input  logic         clr_ovf,
   output logic         overflow,
   output logic [AW:0]  fill
);
   localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic          full, do_wr, do_rd;

   assign full     = (fill == FULL);
   assign rd_valid = (fill != '0);
   assign do_wr    = wr_en && !full;
   assign do_rd    = rd_en && rd_valid;
   assign rd_data  = mem[rptr];

   always_ff @(posedge clk) begin
      if (do_wr) mem[wptr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr     <= '0;
         rptr     <= '0;
         fill     <= '0;
         overflow <= 1'b0;
      end else begin
         if (do_wr) wptr <= wptr + 1'b1;
         if (do_rd) rptr <= rptr + 1'b1;
         case ({do_wr, do_rd})
            2'b10:   fill <= fill + 1'b1;
            2'b01:   fill <= fill - 1'b1;
            default: fill <= fill;
         endcase
         if (clr_ovf) overflow <= 1'b0;
         else if (wr_en && full) overflow <= 1'b1;
      end
   end
endmodule

// File: rtl/fbus_rx.sv
module fbus_rx
   import fbr_pkg::*;
#(
   parameter int DIV_W       = 16,
   parameter int DEPTH       = 256,
   parameter int SYNC_STAGES = 2,
   localparam int AW         = $clog2(DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rx_line,
   input  logic [DIV_W-1:0]   div_val,
   input  logic               rd_en,
   input  logic               clr_ovf,
   output logic [ENTRY_W-1:0] rd_data,
   output logic               rd_valid,
   output logic               overflow,
   output logic               sync_pulse
);
   initial begin
      if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0)
         $fatal(1, "fbus_rx: DEPTH must be a power of two of at least 4");
      if (SYNC_STAGES < 1 || SYNC_STAGES > 4)
         $fatal(1, "fbus_rx: SYNC_STAGES must lie in 1..4");
      if (DIV_W < 1)
         $fatal(1, "fbus_rx: DIV_W must be positive");
   end

   logic rx;

   generate
      if (SYNC_STAGES == 1) begin : g_sync1
         logic rq;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rq <= 1'b1;
            else rq <= rx_line;
         end
         assign rx = rq;
      end else begin : g_syncn
         logic [SYNC_STAGES-1:0] rq;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rq <= '1;
            else rq <= {rq[SYNC_STAGES-2:0], rx_line};
         end
         assign rx = rq[SYNC_STAGES-1];
      end
   endgenerate

   logic              tick;
   logic              chr_vld, chr_perr, chr_ferr;
   logic [BYTE_W-1:0] chr_data;
   logic              idle_sync;
   logic              sof_pend, seen;
   logic              wr_en;
   fbr_entry_t        wr_entry;
   logic [AW:0]       fill;

   fbr_tick #(.DIV_W(DIV_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .div_val(div_val), .tick(tick)
   );

   fbr_char u_char (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rx(rx),
      .vld(chr_vld), .data(chr_data), .perr(chr_perr), .ferr(chr_ferr)
   );

   fbr_idle u_idle (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rx(rx), .sync(idle_sync)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sof_pend <= 1'b0;
         seen     <= 1'b0;
      end else if (idle_sync) begin
         sof_pend <= 1'b1;
         seen     <= 1'b0;
      end else if (chr_vld) begin
         sof_pend <= 1'b0;
         seen     <= 1'b1;
      end
   end

   always_comb begin
      wr_en = chr_vld || (idle_sync && seen);
      if (chr_vld) begin
         wr_entry.tag  = sof_pend ? TAG_SOF : TAG_DATA;
         wr_entry.ferr = chr_ferr;
         wr_entry.perr = chr_perr;
         wr_entry.data = chr_data;
      end else begin
         wr_entry.tag  = TAG_EOF;
         wr_entry.ferr = 1'b0;
         wr_entry.perr = 1'b0;
         wr_entry.data = '0;
      end
   end

   fbr_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_data(wr_entry),
      .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
      .clr_ovf(clr_ovf), .overflow(overflow), .fill(fill)
   );

   assign sync_pulse = idle_sync;
endmodule

// File: rtl/fbr_sva.sv
module fbr_sva #(
   parameter int DEPTH = 256,
   localparam int AW   = $clog2(DEPTH)
) (
   input logic        clk,
   input logic        rst_n,
   input logic        sync_pulse,
   input logic        chr_vld,
   input logic        wr_en,
   input logic        rd_en,
   input logic        rd_valid,
   input logic        clr_ovf,
   input logic        overflow,
   input logic [AW:0] fill
);
   localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

   // R5: the idle-run pulse lasts a single clock
   p_sync_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sync_pulse |=> !sync_pulse);

   // R7: a byte and an idle-run end never compete for the same write slot
   p_no_write_clash_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(chr_vld && sync_pulse));

   // R8: occupancy never exceeds the buffer depth
   p_fill_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= FULL);

   // R8: reading an empty buffer leaves it empty
   p_empty_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_valid && rd_en && !wr_en) |=> !rd_valid);

   // R9: a write into a full buffer raises the flag
   p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (fill == FULL && wr_en && !clr_ovf) |=> overflow);

   // R9: the flag holds until the host clears it
   p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow && !clr_ovf) |=> overflow);

   // R9: the clear strobe drops the flag on the next clock
   p_ovf_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr_ovf |=> !overflow);
endmodule

bind fbus_rx fbr_sva #(.DEPTH(DEPTH)) u_fbr_sva (
   .clk(clk), .rst_n(rst_n), .sync_pulse(sync_pulse), .chr_vld(chr_vld),
   .wr_en(wr_en), .rd_en(rd_en), .rd_valid(rd_valid), .clr_ovf(clr_ovf),
   .overflow(overflow), .fill(fill)
);

// File: tb/test_fbus_rx.sv
module test_fbus_rx;
   localparam int DEPTH = 32;
   localparam int DIV_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             rx_line = 1'b1;
   logic [DIV_W-1:0] div_val = 16'd1;
   logic             rd_en = 1'b0;
   logic             clr_ovf = 1'b0;
   logic [11:0]      rd_data;
   logic             rd_valid, overflow, sync_pulse;

   fbus_rx #(.DIV_W(DIV_W), .DEPTH(DEPTH), .SYNC_STAGES(2)) i_fbus_rx (
      .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .div_val(div_val),
      .rd_en(rd_en), .clr_ovf(clr_ovf), .rd_data(rd_data),
      .rd_valid(rd_valid), .overflow(overflow), .sync_pulse(sync_pulse)
   );

   always #4 clk = ~clk;

   int          n_chk = 0, n_err = 0;
   int          sync_seen = 0, exp_sync = 0;
   logic [11:0] q[$];
   bit          m_sof = 1'b0, m_seen = 1'b0, exp_ovf = 1'b0;

   always @(negedge clk) if (rst_n && sync_pulse) sync_seen++;

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic hold(bit v, int nbits);
      rx_line = v;
      repeat (nbits * 16 * (int'(div_val) + 1)) @(negedge clk);
   endtask

   // reference buffer: keeps entries in order, drops when full
   task automatic mpush(logic [11:0] e);
      if (q.size() < DEPTH) q.push_back(e);
      else exp_ovf = 1'b1;
   endtask

   task automatic send_char(logic [7:0] b, bit bad_par, bit bad_stop);
      hold(1'b0, 1);
      for (int i = 0; i < 8; i++) hold(b[i], 1);
      hold((^b) ^ bad_par, 1);
      hold(!bad_stop, 1);
      if (bad_stop) hold(1'b0, 2);
      mpush({m_sof ? 2'd1 : 2'd0, bad_stop, bad_par, b});
      m_sof  = 1'b0;
      m_seen = 1'b1;
   endtask

   task automatic gap(int nbits);
      hold(1'b1, nbits);
      if (nbits >= 12) begin
         exp_sync++;
         if (m_seen) mpush({2'd2, 10'd0});
         m_seen = 1'b0;
         m_sof  = 1'b1;
      end
   endtask

   task automatic drain(string req);
      while (q.size() > 0) begin
         chk(req, "rd_valid", 32'(rd_valid), 32'd1);
         chk(req, "entry", 32'(rd_data), 32'(q[0]));
         rd_en = 1'b1;
         @(negedge clk);
         rd_en = 1'b0;
         void'(q.pop_front());
      end
      chk(req, "empty after drain", 32'(rd_valid), 32'd0);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=done");
      summary();
   end

   initial begin
      repeat (5) @(negedge clk);
      // R11: reset state
      chk("R11", "rd_valid", 32'(rd_valid), 32'd0);
      chk("R11", "overflow", 32'(overflow), 32'd0);
      chk("R11", "sync_pulse", 32'(sync_pulse), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R5/R7: first idle run pulses once and writes no marker
      gap(14);
      chk("R5", "sync count", 32'(sync_seen), 32'(exp_sync));
      chk("R7", "no marker without bytes", 32'(rd_valid), 32'd0);

      // R8: read on empty buffer has no effect
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      chk("R8", "empty read", 32'(rd_valid), 32'd0);

      // R1/R6/R7: gapless frame, then marker
      send_char(8'h00, 1'b0, 1'b0);
      send_char(8'hFF, 1'b0, 1'b0);
      send_char(8'hA5, 1'b0, 1'b0);
      send_char(8'h3C, 1'b0, 1'b0);
      gap(14);
      drain("R1/R6/R7/R8");
      chk("R5", "sync count", 32'(sync_seen), 32'(exp_sync));

      // R3: parity error on first byte only
      send_char(8'h96, 1'b1, 1'b0);
      send_char(8'h01, 1'b0, 1'b0);
      gap(14);
      drain("R3");

      // R4: stop bit low followed by a low line
      send_char(8'h55, 1'b0, 1'b1);
      gap(14);
      drain("R4");

      // R2: short low pulse rejected; it restarts the idle run (R5)
      rx_line = 1'b0;
      repeat (4) @(negedge clk);
      gap(14);
      chk("R2", "no entry from glitch", 32'(rd_valid), 32'd0);
      chk("R5", "sync count after glitch", 32'(sync_seen), 32'(exp_sync));

      // R10: slower bit time
      div_val = 16'd3;
      gap(2);
      send_char(8'hC3, 1'b0, 1'b0);
      send_char(8'h7E, 1'b0, 1'b0);
      gap(14);
      drain("R10");

      // R9: overflow at fastest rate
      div_val = 16'd0;
      gap(2);
      for (int i = 0; i < 40; i++) send_char(8'(i * 7 + 3), 1'b0, 1'b0);
      gap(14);
      chk("R9", "overflow set", 32'(overflow), 32'(exp_ovf));
      @(negedge clk);
      chk("R9", "overflow sticky", 32'(overflow), 32'd1);
      clr_ovf = 1'b1;
      @(negedge clk);
      clr_ovf = 1'b0;
      chk("R9", "overflow cleared", 32'(overflow), 32'd0);
      drain("R9");
      chk("R5", "final sync count", 32'(sync_seen), 32'(exp_sync));

      summary();
   end
endmodule